// File: doc/BRIEF.md
# Parallel-to-Frame Link Transmitter

This block sits between an application that produces 36-bit parallel words and a downstream bit serializer. It paces the application with a read strobe. Each strobe slot lasts a fixed number of core-clock cycles. When the application holds its data-available input high at the start of a slot, the block pulses the strobe, captures the word, and one cycle later presents a 40-bit frame with a one-cycle frame-valid strobe. When no data is available at the start of a slot, the block still presents a frame, an idle stuffing frame, so that the serial link keeps its synchronization.

Each frame wraps the payload with four overhead bits: a two-bit header, a parity bit and an alternating balance bit. The header tells a data word, a data word carrying a sideband flag, and idle stuffing apart. Parity is always computed inside the block. A mode input selects whether the application's own parity bit is also checked. A wrong external parity raises an active-low error output, but the frame still carries the correct parity. A rising edge on the flag request input is latched. The next data word carries the flag, and that word's strobe slot is one cycle longer.

Top module: `lnk_frame_tx`

## Requirements
- R1: The frame is 40 bits wide. Bits [39:38] hold the header, bit 37 the parity, bit 36 the balance bit and bits [35:0] the payload. Header 2'b01 means a data word, 2'b10 a data word with flag, and 2'b00 idle stuffing. 2'b11 never appears.
- R2: The parity bit of a data frame makes the XOR of the parity bit and the 36 payload bits equal 0 (even parity). This holds in both modes, including when the external parity was wrong.
- R3: While `int_par` is high at capture, `par_in` has no effect on the frame, and `par_err_n` is high during the frame that follows.
- R4: While `int_par` is low at capture, `par_err_n` goes low together with the frame's `frm_vld` when `par_in` differs from the computed parity, and is high when they agree. It keeps that value until the next frame.
- R5: `rd_stb` is a single-cycle pulse. It is issued only in the first cycle of a slot, and only while `dat_avail` and `pll_ok` are high. The word on `wd_in` in that cycle appears as a data frame with `frm_vld` high in the next cycle.
- R6: While `dat_avail` stays high and no flag is pending, one word is taken every `STB_PER` cycles.
- R7: If `dat_avail` is lowered after one strobe, exactly one word is taken. Every slot that starts with `dat_avail` low yields an idle frame with header 2'b00 and with parity and payload all zero.
- R8: A rising edge on `flag_req` sets a pending flag. The next data word, including one strobed in the same cycle as the edge, is sent with header 2'b10, and the flag is then cleared.
- R9: The slot of a flagged word lasts `STB_PER`+1 cycles. The slot after it returns to `STB_PER` cycles.
- R10: The balance bit alternates from one frame to the next, and the first frame after reset carries 0.
- R11: While `pll_ok` is low, no strobe is issued and no new frame starts. When `pll_ok` returns, a slot starts in its first high cycle.
- R12: Reset is synchronous and active low. It leaves `rd_stb` and `frm_vld` low, `par_err_n` high, no flag pending, and the next balance bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_ok | input | 1 | Lock indication; block idles while low |
| dat_avail | input | 1 | Application has a word ready |
| wd_in | input | 36 | Parallel payload word |
| par_in | input | 1 | Application-supplied parity bit |
| int_par | input | 1 | 1: ignore `par_in`; 0: check it |
| flag_req | input | 1 | Sideband flag request, rising-edge sensitive |
| rd_stb | output | 1 | Read strobe; word is taken in this cycle |
| frm_out | output | 40 | Frame for the serializer |
| frm_vld | output | 1 | One-cycle strobe marking a new frame |
| par_err_n | output | 1 | Active-low external parity mismatch |

## Verification
The flag request edge and the read strobe can fall in the same cycle. The latched flag and the slot stretch must then act on the word being captured, and must not wait for the following one. The bench provokes this on purpose: it raises `flag_req`, `pll_ok` and `dat_avail` together, so that the first slot starts in that very cycle. It then judges the result by a 2'b10 header on that frame and by a gap of `STB_PER`+1 cycles before the next frame. A parity mismatch can also arrive on a flagged word. Random runs mix both, and the bench checks the header, the parity bit and `par_err_n` of every frame against a model it computes itself.

// File: rtl/lnk_frame_pkg.sv
// Shared definitions for the parallel-to-frame link transmitter.
// Assumes a frame is payload plus four overhead bits laid out as
// {header[1:0], parity, balance, payload}.
package lnk_frame_pkg;

    // Width of the frame header field.
    localparam int HDR_W = 2;
    // Overhead bits added to every payload word.
    localparam int OVH_W = 4;

    // Header codes; the receiving side decodes these.
    typedef enum logic [HDR_W-1:0] {
        HDR_IDLE = 2'b00,
        HDR_DATA = 2'b01,
        HDR_FLAG = 2'b10
    } hdr_e;

endpackage

// File: rtl/lnk_slot_timer.sv
// Slot timer: produces a one-cycle slot_start at the beginning of every
// strobe slot. A normal slot lasts STB_PER cycles; a slot marked long at
// its start lasts STB_PER+1. Assumes STB_PER >= 2. While ready is low
// the timer waits at zero, so a slot starts in the first ready cycle.
module lnk_slot_timer #(
    parameter int STB_PER = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic stretch,
    output logic slot_start
);

    localparam int CNT_W = $clog2(STB_PER + 1);
    localparam logic [CNT_W-1:0] LAST_NORM = CNT_W'(STB_PER - 1);
    localparam logic [CNT_W-1:0] LAST_LONG = CNT_W'(STB_PER);

    logic [CNT_W-1:0] cnt;
    logic             long_q;
    logic [CNT_W-1:0] last;

    // Slot begins whenever the counter sits at zero and the link is ready.
    assign slot_start = ready && (cnt == '0);

    // Final count of the current slot, one more when the slot is stretched.
    always_comb begin
        last = long_q ? LAST_LONG : LAST_NORM;
    end

    // Advance the slot counter and latch the stretch request at slot start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            long_q <= 1'b0;
        end else if (!ready) begin
            cnt    <= '0;
            long_q <= 1'b0;
        end else if (slot_start) begin
            cnt    <= CNT_W'(1);
            long_q <= stretch;
        end else if (cnt == last) begin
            cnt    <= '0;
        end else begin
            cnt    <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lnk_flag_catch.sv
// Flag catcher: turns a rising edge on the request input into a pending
// flag. The flag is reported (hit) from the cycle of the edge onward and
// is cleared by consume. An edge arriving in the consume cycle is folded
// into that consumption. Assumes the request is synchronous to clk.
module lnk_flag_catch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic consume,
    output logic hit
);

    logic req_q;
    logic pend;
    logic edge_seen;

    // Rising edge of the request relative to the previous cycle.
    assign edge_seen = req && !req_q;
    // Flag visible now: either already pending or arriving this cycle.
    assign hit = pend || edge_seen;

    // Track the request level and hold the pending flag until consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            req_q <= req;
            pend  <= consume ? 1'b0 : hit;
        end
    end

endmodule

// File: rtl/lnk_par_unit.sv
// Parity unit: computes the frame parity of a word and flags a mismatch
// against the externally supplied bit when external mode is selected.
// ODD_PAR picks odd parity instead of the default even parity.
// Purely combinational.
module lnk_par_unit #(
    parameter int DATA_W  = 36,
    parameter bit ODD_PAR = 1'b0
) (
    input  logic [DATA_W-1:0] word,
    input  logic              par_ext,
    input  logic              int_mode,
    output logic              par_calc,
    output logic              mismatch
);

    generate
        if (ODD_PAR) begin : g_odd
            // Odd variant: parity plus payload has an odd count of ones.
            assign par_calc = ~(^word);
        end else begin : g_even
            // Even variant: parity plus payload has an even count of ones.
            assign par_calc = ^word;
        end
    endgenerate

    // External parity is judged only when internal mode is off.
    assign mismatch = !int_mode && (par_ext != par_calc);

endmodule

// File: rtl/lnk_frame_pack.sv
// Frame packer: at each slot start registers one frame. A taken word
// becomes a data or flagged data frame; an untaken slot becomes an idle
// frame. The balance bit flips on every frame. The error flag is updated
// with each frame and then held. Assumes slot_start is one cycle wide.
module lnk_frame_pack
    import lnk_frame_pkg::*;
#(
    parameter int DATA_W = 36,
    localparam int FRAME_W = DATA_W + OVH_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slot_start,
    input  logic               take,
    input  logic               flagged,
    input  logic [DATA_W-1:0]  word,
    input  logic               par_calc,
    input  logic               mismatch,
    output logic [FRAME_W-1:0] frame,
    output logic               frame_vld,
    output logic               err_n
);

    logic bal;
    hdr_e hdr;

    // Header for a taken word depends on the flag.
    always_comb begin
        hdr = flagged ? HDR_FLAG : HDR_DATA;
    end

    // Register the frame, its strobe, the balance bit and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame     <= '0;
            frame_vld <= 1'b0;
            err_n     <= 1'b1;
            bal       <= 1'b0;
        end else begin
            frame_vld <= slot_start;
            if (slot_start) begin
                bal <= ~bal;
                if (take) begin
                    frame <= {hdr, par_calc, bal, word};
                    err_n <= ~mismatch;
                end else begin
                    frame <= {HDR_IDLE, 1'b0, bal, {DATA_W{1'b0}}};
                    err_n <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lnk_frame_tx.sv
// Parallel-to-frame link transmitter top. It paces the application with a
// read strobe, one slot at a time, and packs each taken word (or an idle
// filler) into a frame for the serializer. Assumes every input is
// synchronous to clk and STB_PER >= 2.
module lnk_frame_tx
    import lnk_frame_pkg::*;
#(
    parameter int DATA_W  = 36,
    parameter int STB_PER = 4,
    parameter bit ODD_PAR = 1'b0,
    localparam int FRAME_W = DATA_W + OVH_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pll_ok,
    input  logic               dat_avail,
    input  logic [DATA_W-1:0]  wd_in,
    input  logic               par_in,
    input  logic               int_par,
    input  logic               flag_req,
    output logic               rd_stb,
    output logic [FRAME_W-1:0] frm_out,
    output logic               frm_vld,
    output logic               par_err_n
);

    logic slot_start;
    logic flag_hit;
    logic par_calc;
    logic mismatch;
    logic stretch;

    // A word is taken only at a slot start with data offered.
    assign rd_stb  = slot_start && dat_avail;
    // A flagged word lengthens its own slot by one cycle.
    assign stretch = rd_stb && flag_hit;

    lnk_slot_timer #(
        .STB_PER (STB_PER)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (pll_ok),
        .stretch    (stretch),
        .slot_start (slot_start)
    );

    lnk_flag_catch u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (flag_req),
        .consume (rd_stb),
        .hit     (flag_hit)
    );

    lnk_par_unit #(
        .DATA_W  (DATA_W),
        .ODD_PAR (ODD_PAR)
    ) u_par (
        .word     (wd_in),
        .par_ext  (par_in),
        .int_mode (int_par),
        .par_calc (par_calc),
        .mismatch (mismatch)
    );

    lnk_frame_pack #(
        .DATA_W (DATA_W)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_start (slot_start),
        .take       (rd_stb),
        .flagged    (flag_hit),
        .word       (wd_in),
        .par_calc   (par_calc),
        .mismatch   (mismatch),
        .frame      (frm_out),
        .frame_vld  (frm_vld),
        .err_n      (par_err_n)
    );

endmodule

// File: rtl/lnk_frame_tx_chk.sv
// Property checker for lnk_frame_tx, attached by bind. Observes ports only.
module lnk_frame_tx_chk #(
    parameter int DATA_W  = 36,
    parameter bit ODD_PAR = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pll_ok,
    input logic              dat_avail,
    input logic              int_par,
    input logic              rd_stb,
    input logic [DATA_W+3:0] frm_out,
    input logic              frm_vld,
    input logic              par_err_n
);

    logic       seen;
    logic       last_bal;
    logic [1:0] hdr;

    assign hdr = frm_out[DATA_W+3:DATA_W+2];

    // Remember the balance bit of the previous frame since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            last_bal <= 1'b0;
        end else if (frm_vld) begin
            seen     <= 1'b1;
            last_bal <= frm_out[DATA_W];
        end
    end

    a_r5_stb_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> (dat_avail && pll_ok));

    a_r11_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_ok |-> !rd_stb);

    a_r5_frame_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (frm_vld && hdr != 2'b00));

    a_r5_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

    a_r1_hdr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |-> hdr != 2'b11);

    a_r2_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && hdr != 2'b00) |-> ((^{frm_out[DATA_W+1], frm_out[DATA_W-1:0]}) == ODD_PAR));

    a_r7_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && hdr == 2'b00) |-> (frm_out[DATA_W+1] == 1'b0 && frm_out[DATA_W-1:0] == '0));

    a_r3_no_err_internal: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && int_par) |=> par_err_n);

    a_r10_balance_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && seen) |-> (frm_out[DATA_W] != last_bal));

endmodule

bind lnk_frame_tx lnk_frame_tx_chk #(
    .DATA_W  (DATA_W),
    .ODD_PAR (ODD_PAR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pll_ok    (pll_ok),
    .dat_avail (dat_avail),
    .int_par   (int_par),
    .rd_stb    (rd_stb),
    .frm_out   (frm_out),
    .frm_vld   (frm_vld),
    .par_err_n (par_err_n)
);

// File: tb/sim_lnk_frame_tx.sv
`timescale 1ns/1ps
module sim_lnk_frame_tx;

    localparam int DW  = 36;
    localparam int PER = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pll_ok = 1'b0;
    logic          dat_avail = 1'b0;
    logic [DW-1:0] wd_in = '0;
    logic          par_in = 1'b0;
    logic          int_par = 1'b1;
    logic          flag_req = 1'b0;
    logic          rd_stb;
    logic [DW+3:0] frm_out;
    logic          frm_vld;
    logic          par_err_n;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned stb_count = 0;
    bit          done = 1'b0;

    // Bench model state
    bit            flag_model = 1'b0;
    bit            bal_exp = 1'b0;
    bit            prev_stb = 1'b0;
    bit            prev_pll = 1'b0;
    bit            gap_known = 1'b0;
    bit            last_flag = 1'b0;
    int            gap_cnt = 0;
    logic [DW+3:0] pend_frm = '0;
    bit            pend_perr = 1'b1;
    bit            pend_int = 1'b1;

    always #2.5 clk = ~clk;

    lnk_frame_tx #(.DATA_W(DW), .STB_PER(PER)) u0 (
        .clk(clk), .rst_n(rst_n), .pll_ok(pll_ok), .dat_avail(dat_avail),
        .wd_in(wd_in), .par_in(par_in), .int_par(int_par), .flag_req(flag_req),
        .rd_stb(rd_stb), .frm_out(frm_out), .frm_vld(frm_vld), .par_err_n(par_err_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected frame of a captured word, per R1/R2/R8.
    function automatic logic [DW+3:0] data_frame(input logic [DW-1:0] w, input bit flg, input bit b);
        return {(flg ? 2'b10 : 2'b01), ^w, b, w};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Monitor: samples at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            bal_exp = 1'b0; prev_stb = 1'b0; prev_pll = 1'b0;
            gap_known = 1'b0; gap_cnt = 0;
        end else begin
            gap_cnt++;
            if (frm_vld) begin
                logic [DW+3:0] exp_f;
                bit exp_e;
                bit flg;
                if (prev_stb) begin
                    exp_f = pend_frm;
                    exp_f[DW] = bal_exp;
                    exp_e = pend_perr;
                    flg = (pend_frm[DW+3:DW+2] == 2'b10);
                    chk(frm_out == exp_f, flg ? "R8" : "R1", "data frame", 64'(frm_out), 64'(exp_f));
                    chk(par_err_n == exp_e, pend_int ? "R3" : "R4", "par_err_n", 64'(par_err_n), 64'(exp_e));
                end else begin
                    exp_f = {2'b00, 1'b0, bal_exp, {DW{1'b0}}};
                    flg = 1'b0;
                    chk(frm_out == exp_f, "R7", "idle frame", 64'(frm_out), 64'(exp_f));
                    chk(par_err_n == 1'b1, "R7", "par_err_n idle", 64'(par_err_n), 64'd1);
                end
                if (gap_known)
                    chk(gap_cnt == (last_flag ? PER + 1 : PER), last_flag ? "R9" : "R6",
                        "slot length", 64'(gap_cnt), 64'(last_flag ? PER + 1 : PER));
                gap_known = 1'b1;
                gap_cnt = 0;
                last_flag = flg;
                bal_exp = ~bal_exp;
            end else if (prev_stb) begin
                chk(1'b0, "R5", "frame missing after strobe", 64'd0, 64'd1);
            end
            if (rd_stb) begin
                chk(dat_avail == 1'b1, "R5", "strobe without data", 64'(dat_avail), 64'd1);
                pend_frm  = data_frame(wd_in, flag_model, 1'b0);
                pend_int  = int_par;
                pend_perr = int_par ? 1'b1 : (par_in == ^wd_in);
                flag_model = 1'b0;
                stb_count++;
            end
            prev_stb = rd_stb;
            if (!pll_ok) begin
                chk(rd_stb == 1'b0, "R11", "strobe while unlocked", 64'(rd_stb), 64'd0);
                if (!prev_pll)
                    chk(frm_vld == 1'b0, "R11", "frame while unlocked", 64'(frm_vld), 64'd0);
                gap_known = 1'b0;
            end
            prev_pll = pll_ok;
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned c0;
        void'($urandom(32'h5eed_0042));
        // R12: reset state
        repeat (4) step();
        @(negedge clk);
        chk(rd_stb == 0, "R12", "rd_stb in reset", 64'(rd_stb), 0);
        chk(frm_vld == 0, "R12", "frm_vld in reset", 64'(frm_vld), 0);
        chk(par_err_n == 1, "R12", "par_err_n in reset", 64'(par_err_n), 1);
        step();
        rst_n = 1'b1;
        dat_avail = 1'b1;
        repeat (5) step();          // R11: unlocked, data offered, no strobe
        chk(stb_count == 0, "R11", "strobes while unlocked", 64'(stb_count), 0);

        // R6: burst with internal parity and wrong external parity (R3)
        pll_ok = 1'b1; int_par = 1'b1; wd_in = 36'h0_1234_5678; par_in = ~(^wd_in);
        c0 = stb_count;
        repeat (4 * PER) step();
        chk(stb_count - c0 == 4, "R6", "burst strobe count", 64'(stb_count - c0), 4);

        // R7: single word with external parity mismatch (R4)
        dat_avail = 1'b0;
        repeat (2 * PER) step();
        int_par = 1'b0; wd_in = 36'hA_5A5A_0F0F; par_in = ~(^wd_in);
        c0 = stb_count; dat_avail = 1'b1;
        while (stb_count == c0) step();
        dat_avail = 1'b0;
        c0 = stb_count;
        repeat (5 * PER) step();
        chk(stb_count == c0, "R7", "extra word after single strobe", 64'(stb_count - c0), 0);

        // R8/R9: flag edge in the very cycle of the first strobe
        pll_ok = 1'b0;
        repeat (3) step();
        c0 = stb_count;
        pll_ok = 1'b1; dat_avail = 1'b1; flag_req = 1'b1; flag_model = 1'b1;
        wd_in = 36'hF_0000_0001; par_in = ^wd_in;
        @(negedge clk);
        chk(rd_stb == 1'b1, "R11", "slot on first locked cycle", 64'(rd_stb), 1);
        step();
        flag_req = 1'b0;
        repeat (3 * PER) step();

        // R8: flag raised during idle rides on the next data word
        dat_avail = 1'b0;
        repeat (PER) step();
        flag_req = 1'b1; flag_model = 1'b1;
        step(); flag_req = 1'b0;
        repeat (3 * PER) step();
        dat_avail = 1'b1;
        repeat (3 * PER) step();

        // Random mixture
        for (int i = 0; i < 4000; i++) begin
            dat_avail = ($urandom() % 4) != 0;
            wd_in = {4'($urandom()), 32'($urandom())};
            par_in = (^wd_in) ^ (($urandom() % 5) == 0);
            if (i % 50 == 0) int_par = $urandom() % 2;
            if (flag_req) flag_req = 1'b0;
            else if (($urandom() % 13) == 0) begin flag_req = 1'b1; flag_model = 1'b1; end
            if (!pll_ok) pll_ok = ($urandom() % 3) == 0;
            else if (($urandom() % 200) == 0) pll_ok = 1'b0;
            step();
        end
        flag_req = 1'b0;
        repeat (3 * PER) step();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule